// File: doc/BRIEF.md
# Error Syndrome Capture Unit

This block records the first error raised by a request-handling node and keeps that record until software releases it. The error source gives a single-cycle strobe together with a 4-bit error type, an opcode, a source ID, a transaction ID, a set of request attributes, a 44-bit faulting address and a path indication (request path or response path). The first strobe that arrives while the log is empty fills the two 64-bit syndrome words and locks them. Any strobe that arrives while the log is locked leaves the record alone and raises a multiple-errors flag.

Software uses a 64-bit register port for access. It reads the syndrome words at 0x400 and 0x408. It releases the two flags by writing strobes to a write-only clear word at 0x480. It sets the notification enables in a control word at 0x500.

The block also drives two single-cycle notification pulses toward the management node, one for each error path. Each pulse is gated by its own enable bit.

Control is a two-state machine:
- `ST_EMPTY` means no error is logged.
- `ST_LOCKED` means a record is held.

Its transitions are:
- CAPTURE (`ST_EMPTY`→`ST_LOCKED`) on a strobe.
- OVERFLOW (`ST_LOCKED`→`ST_LOCKED`) on a strobe with no first-valid clear. It sets the multiple-errors flag.
- RECAPTURE (`ST_LOCKED`→`ST_LOCKED`) on a strobe together with a first-valid clear. It overwrites the record.
- RELEASE (`ST_LOCKED`→`ST_EMPTY`) on a first-valid clear with no strobe.

Top module: `err_syndrome_unit`

## Requirements
- R1: After reset, syndrome word 0 (offset 0x400) and syndrome word 1 (offset 0x408) read as zero, the control word (offset 0x500) reads 0x4, and both notification outputs are low.
- R2: A strobe while first-valid is 0 captures the log into word 0 and sets first-valid (bit 62). The log fields are placed as follows:
  - error type in bits 3:0
  - opcode in 8:4
  - source ID in 15:9
  - transaction ID in 26:16
  - dynamic-credit flag in 27
  - non-secure flag in 28
  - order in 30:29
  - memory attributes in 34:31
  - snoop attributes in 36:35
  - size in 39:37
  - credit type in 41:40
  - bit 42 as zero
- R3: Source ID and transaction ID are logged only when the error type is 4'b0100 (downstream write response error). For every other type those fields are logged as zero.
- R4: Word 1 holds the captured address in bits 43:0. Its bits 63:44 read as zero.
- R5: A strobe while first-valid is 1 leaves both syndrome words' log and address contents unchanged and sets multiple-errors (word 0 bit 59).
- R6: Writing 1 to bit 62 of the clear word (offset 0x480) clears first-valid, and writing 1 to bit 59 clears multiple-errors. Writes to any other bit of the clear word have no effect, and the clear word always reads as zero.
- R7: When a first-valid clear and a strobe occur in the same cycle, the new error is captured and first-valid stays 1.
- R8: When a multiple-errors clear and a strobe occur in the same cycle while first-valid is 1, multiple-errors ends up set.
- R9: In the control word, bit 2 enables request-path notification (reset 1) and bit 3 enables response-path notification (reset 0). All other control bits read as zero.
- R10: Every strobe drives a one-cycle notification pulse in the cycle after the strobe, whether or not the log is locked. The pulse goes on `notify_req_o` when the path input is 0 and the request-path enable is set, and on `notify_rsp_o` when the path input is 1 and the response-path enable is set.
- R11: A read returns its data with `reg_rvalid_o` high in the cycle after the request. A read of an unmapped offset returns zero, and a write to an unmapped offset changes nothing.
- R12: Word 0 bits 63, 61:60 and 58:43 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_vld_i | input | 1 | Single-cycle error strobe |
| err_on_rsp_i | input | 1 | Error path: 0 request, 1 response |
| err_type_i | input | 4 | Error type code |
| err_opcode_i | input | 5 | Opcode of the failing request |
| err_srcid_i | input | 7 | Source ID |
| err_txnid_i | input | 11 | Transaction ID |
| err_dyncrd_i | input | 1 | Dynamic-credit flag |
| err_ns_i | input | 1 | Non-secure flag |
| err_order_i | input | 2 | Ordering attribute |
| err_memattr_i | input | 4 | Memory attributes |
| err_snpattr_i | input | 2 | Snoop attributes |
| err_size_i | input | 3 | Transfer size |
| err_crdtype_i | input | 2 | Credit type |
| err_addr_i | input | 44 | Faulting address |
| reg_req_i | input | 1 | Register access request |
| reg_wr_i | input | 1 | 1 write, 0 read |
| reg_addr_i | input | 16 | Register byte offset |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data |
| reg_rvalid_o | output | 1 | Read data valid |
| notify_req_o | output | 1 | Request-path error notification pulse |
| notify_rsp_o | output | 1 | Response-path error notification pulse |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions:
- a first-valid clear landing in the exact cycle a new strobe arrives, and
- a multiple-errors clear racing a strobe while the log is locked.

The bench reaches them with a task that raises the strobe and the clear-word write on the same falling edge, so that both are sampled by one rising edge. It then reads both syndrome words back and checks that the record is the new one and that each flag ended where its priority rule puts it.

// File: rtl/err_syn_pkg.sv
package err_syn_pkg;
    localparam int REG_AW = 16;
    localparam int REG_DW = 64;
    localparam int ADDR_W = 44;
    localparam int LOG_W  = 43;

    localparam logic [REG_AW-1:0] OFF_SYN0 = 16'h0400;
    localparam logic [REG_AW-1:0] OFF_SYN1 = 16'h0408;
    localparam logic [REG_AW-1:0] OFF_CLR  = 16'h0480;
    localparam logic [REG_AW-1:0] OFF_CTRL = 16'h0500;

    localparam int BIT_FIRST = 62;
    localparam int BIT_MULT  = 59;
    localparam int BIT_REQEN = 2;
    localparam int BIT_RSPEN = 3;

    localparam logic [3:0] TYPE_DWR_RESP = 4'b0100;

    typedef enum logic {ST_EMPTY = 1'b0, ST_LOCKED = 1'b1} log_state_t;

    typedef struct packed {
        logic [3:0]  etype;
        logic [4:0]  opcode;
        logic [6:0]  srcid;
        logic [10:0] txnid;
        logic        dyncrd;
        logic        ns;
        logic [1:0]  order;
        logic [3:0]  memattr;
        logic [1:0]  snpattr;
        logic [2:0]  size;
        logic [1:0]  crdtype;
    } err_rec_t;

    function automatic logic [LOG_W-1:0] pack_log(input err_rec_t r);
        logic dwr;
        dwr = (r.etype == TYPE_DWR_RESP);
        return {1'b0, r.crdtype, r.size, r.snpattr, r.memattr, r.order,
                r.ns, r.dyncrd, dwr ? r.txnid : 11'd0,
                dwr ? r.srcid : 7'd0, r.opcode, r.etype};
    endfunction
endpackage

// File: rtl/err_log_fsm.sv
module err_log_fsm
    import err_syn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_vld,
    input  err_rec_t          rec,
    input  logic [ADDR_W-1:0] addr,
    input  logic              clr_first,
    input  logic              clr_mult,
    output logic              first_vld,
    output logic              mult_err,
    output logic [LOG_W-1:0]  log_q,
    output logic [ADDR_W-1:0] addr_q
);
    log_state_t state_q, state_d;
    logic       load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state and load decision
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_EMPTY: if (err_vld) begin
                state_d = ST_LOCKED;           // CAPTURE
                load    = 1'b1;
            end
            ST_LOCKED: begin
                if (err_vld && clr_first) load = 1'b1;   // RECAPTURE
                else if (clr_first) state_d = ST_EMPTY;  // RELEASE
            end
        endcase
    end

    // outputs: log contents and overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_q    <= '0;
            addr_q   <= '0;
            mult_err <= 1'b0;
        end else begin
            if (load) begin
                log_q  <= pack_log(rec);
                addr_q <= addr;
            end
            if (state_q == ST_LOCKED && err_vld && !clr_first) mult_err <= 1'b1; // OVERFLOW
            else if (clr_mult) mult_err <= 1'b0;
        end
    end

    assign first_vld = (state_q == ST_LOCKED);

    AST_FIRST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_vld && err_vld) |=> first_vld); // R2
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (first_vld && err_vld && !clr_first) |=> ($stable(log_q) && $stable(addr_q))); // R5
    AST_MULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (first_vld && err_vld && !clr_first) |=> mult_err); // R8
    AST_RECAPTURE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && clr_first) |=> first_vld); // R7
endmodule

// File: rtl/err_reg_decode.sv
module err_reg_decode
    import err_syn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              first_vld,
    input  logic              mult_err,
    input  logic [LOG_W-1:0]  log_q,
    input  logic [ADDR_W-1:0] addr_q,
    output logic [REG_DW-1:0] rdata,
    output logic              rvalid,
    output logic              clr_first,
    output logic              clr_mult,
    output logic              req_en,
    output logic              rsp_en
);
    localparam int PAD1 = REG_DW - ADDR_W;

    logic              wr_ok, rd_ok;
    logic [REG_DW-1:0] rd_mux;
    logic              unused_wdata;

    assign wr_ok     = reg_req && reg_wr;
    assign rd_ok     = reg_req && !reg_wr;
    assign clr_first = wr_ok && (reg_addr == OFF_CLR) && reg_wdata[BIT_FIRST];
    assign clr_mult  = wr_ok && (reg_addr == OFF_CLR) && reg_wdata[BIT_MULT];
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_en <= 1'b1;
            rsp_en <= 1'b0;
        end else if (wr_ok && reg_addr == OFF_CTRL) begin
            req_en <= reg_wdata[BIT_REQEN];
            rsp_en <= reg_wdata[BIT_RSPEN];
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (reg_addr)
            OFF_SYN0: rd_mux = {1'b0, first_vld, 2'b00, mult_err, 16'd0, log_q};
            OFF_SYN1: rd_mux = {{PAD1{1'b0}}, addr_q};
            OFF_CTRL: begin
                rd_mux[BIT_REQEN] = req_en;
                rd_mux[BIT_RSPEN] = rsp_en;
            end
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_ok;
            rdata  <= rd_ok ? rd_mux : '0;
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |=> rvalid); // R11
    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && reg_addr == OFF_CLR) |=> (rdata == '0)); // R6
endmodule

// File: rtl/err_notify.sv
module err_notify (
    input  logic clk,
    input  logic rst_n,
    input  logic err_vld,
    input  logic err_on_rsp,
    input  logic req_en,
    input  logic rsp_en,
    output logic notify_req,
    output logic notify_rsp
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify_req <= 1'b0;
            notify_rsp <= 1'b0;
        end else begin
            notify_req <= err_vld && !err_on_rsp && req_en;
            notify_rsp <= err_vld &&  err_on_rsp && rsp_en;
        end
    end

    AST_NOTIFY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (notify_req || notify_rsp) |-> $past(err_vld)); // R10
    AST_NOTIFY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({notify_req, notify_rsp})); // R10
endmodule

// File: rtl/err_syndrome_unit.sv
module err_syndrome_unit
    import err_syn_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        err_vld_i,
    input  logic        err_on_rsp_i,
    input  logic [3:0]  err_type_i,
    input  logic [4:0]  err_opcode_i,
    input  logic [6:0]  err_srcid_i,
    input  logic [10:0] err_txnid_i,
    input  logic        err_dyncrd_i,
    input  logic        err_ns_i,
    input  logic [1:0]  err_order_i,
    input  logic [3:0]  err_memattr_i,
    input  logic [1:0]  err_snpattr_i,
    input  logic [2:0]  err_size_i,
    input  logic [1:0]  err_crdtype_i,
    input  logic [43:0] err_addr_i,
    input  logic        reg_req_i,
    input  logic        reg_wr_i,
    input  logic [15:0] reg_addr_i,
    input  logic [63:0] reg_wdata_i,
    output logic [63:0] reg_rdata_o,
    output logic        reg_rvalid_o,
    output logic        notify_req_o,
    output logic        notify_rsp_o
);
    err_rec_t          rec;
    logic              clr_first, clr_mult, first_vld, mult_err, req_en, rsp_en;
    logic [LOG_W-1:0]  log_q;
    logic [ADDR_W-1:0] addr_q;

    assign rec = '{etype: err_type_i, opcode: err_opcode_i, srcid: err_srcid_i,
                   txnid: err_txnid_i, dyncrd: err_dyncrd_i, ns: err_ns_i,
                   order: err_order_i, memattr: err_memattr_i,
                   snpattr: err_snpattr_i, size: err_size_i, crdtype: err_crdtype_i};

    err_log_fsm u_log (
        .clk(clk), .rst_n(rst_n), .err_vld(err_vld_i), .rec(rec), .addr(err_addr_i),
        .clr_first(clr_first), .clr_mult(clr_mult), .first_vld(first_vld),
        .mult_err(mult_err), .log_q(log_q), .addr_q(addr_q)
    );

    err_reg_decode u_dec (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req_i), .reg_wr(reg_wr_i),
        .reg_addr(reg_addr_i), .reg_wdata(reg_wdata_i), .first_vld(first_vld),
        .mult_err(mult_err), .log_q(log_q), .addr_q(addr_q), .rdata(reg_rdata_o),
        .rvalid(reg_rvalid_o), .clr_first(clr_first), .clr_mult(clr_mult),
        .req_en(req_en), .rsp_en(rsp_en)
    );

    err_notify u_ntf (
        .clk(clk), .rst_n(rst_n), .err_vld(err_vld_i), .err_on_rsp(err_on_rsp_i),
        .req_en(req_en), .rsp_en(rsp_en), .notify_req(notify_req_o),
        .notify_rsp(notify_rsp_o)
    );
endmodule

// File: tb/err_syndrome_unit_tb.sv
module err_syndrome_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] M_FIRST = 64'h1 << 62;
    localparam logic [63:0] M_MULT  = 64'h1 << 59;

    logic        clk = 0, rst_n = 0;
    logic        err_vld = 0, err_on_rsp = 0;
    logic [3:0]  err_type = 0;
    logic [4:0]  err_opcode = 0;
    logic [6:0]  err_srcid = 0;
    logic [10:0] err_txnid = 0;
    logic        err_dyncrd = 0, err_ns = 0;
    logic [1:0]  err_order = 0, err_snpattr = 0, err_crdtype = 0;
    logic [3:0]  err_memattr = 0;
    logic [2:0]  err_size = 0;
    logic [43:0] err_addr = 0;
    logic        reg_req = 0, reg_wr = 0;
    logic [15:0] reg_addr = 0;
    logic [63:0] reg_wdata = 0, reg_rdata;
    logic        reg_rvalid, notify_req, notify_rsp;
    int          checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    err_syndrome_unit u_dut (
        .clk(clk), .rst_n(rst_n), .err_vld_i(err_vld), .err_on_rsp_i(err_on_rsp),
        .err_type_i(err_type), .err_opcode_i(err_opcode), .err_srcid_i(err_srcid),
        .err_txnid_i(err_txnid), .err_dyncrd_i(err_dyncrd), .err_ns_i(err_ns),
        .err_order_i(err_order), .err_memattr_i(err_memattr), .err_snpattr_i(err_snpattr),
        .err_size_i(err_size), .err_crdtype_i(err_crdtype), .err_addr_i(err_addr),
        .reg_req_i(reg_req), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .reg_rvalid_o(reg_rvalid),
        .notify_req_o(notify_req), .notify_rsp_o(notify_rsp)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected log from a stimulus pattern, field positions per R2/R3
    function automatic logic [42:0] exp_log(input logic [3:0] ty, input logic [63:0] p);
        logic [42:0] l;
        logic dwr;
        dwr = (ty == 4'b0100);
        l = '0;
        l[3:0]   = ty;
        l[8:4]   = p[4:0];
        l[15:9]  = dwr ? p[11:5] : 7'd0;
        l[26:16] = dwr ? p[22:12] : 11'd0;
        l[27]    = p[23];
        l[28]    = p[24];
        l[30:29] = p[26:25];
        l[34:31] = p[30:27];
        l[36:35] = p[32:31];
        l[39:37] = p[35:33];
        l[41:40] = p[37:36];
        return l;
    endfunction

    function automatic logic [63:0] exp_w0(input logic [42:0] l, input logic f, input logic m);
        return {1'b0, f, 2'b00, m, 16'd0, l};
    endfunction

    task automatic set_fields(input logic [3:0] ty, input logic path, input logic [63:0] p);
        err_type = ty; err_on_rsp = path;
        err_opcode = p[4:0]; err_srcid = p[11:5]; err_txnid = p[22:12];
        err_dyncrd = p[23]; err_ns = p[24]; err_order = p[26:25];
        err_memattr = p[30:27]; err_snpattr = p[32:31]; err_size = p[35:33];
        err_crdtype = p[37:36]; err_addr = p[63:20];
    endtask

    // strobe and optional same-cycle register write; returns at the falling edge after
    task automatic pulse(input logic do_err, input logic [3:0] ty, input logic path,
                         input logic [63:0] p, input logic do_wr,
                         input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        set_fields(ty, path, p);
        err_vld = do_err;
        reg_req = do_wr; reg_wr = do_wr; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        err_vld = 0; reg_req = 0; reg_wr = 0;
    endtask

    task automatic strobe(input logic [3:0] ty, input logic path, input logic [63:0] p);
        pulse(1'b1, ty, path, p, 1'b0, 16'h0, 64'h0);
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [63:0] d);
        pulse(1'b0, 4'h0, 1'b0, 64'h0, 1'b1, a, d);
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_req = 1; reg_wr = 0; reg_addr = a;
        @(negedge clk);
        reg_req = 0;
        check("R11 rvalid", {63'd0, reg_rvalid}, 64'd1);
        d = reg_rdata;
    endtask

    task automatic clear_all();
        reg_write(16'h0480, M_FIRST | M_MULT);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        check("R1 notify_req", {63'd0, notify_req}, 64'd0);
        check("R1 notify_rsp", {63'd0, notify_rsp}, 64'd0);
        reg_read(16'h0400, d); check("R1 word0", d, 64'd0);
        reg_read(16'h0408, d); check("R1 word1", d, 64'd0);
        reg_read(16'h0500, d); check("R1 ctrl", d, 64'h4);
    endtask

    task automatic t_capture();
        logic [63:0] d, p;
        p = 64'hA5C3_96F0_1E2D_3B4C;
        strobe(4'b0100, 1'b0, p);
        reg_read(16'h0400, d); check("R2 R3 R12 capture dwr", d, exp_w0(exp_log(4'b0100, p), 1, 0));
        reg_read(16'h0408, d); check("R4 address", d, {20'd0, p[63:20]});
        clear_all();
        p = 64'h5F3A_C8E1_7BD6_FFFF;
        strobe(4'b0010, 1'b0, p);
        reg_read(16'h0400, d); check("R3 ids zero", d, exp_w0(exp_log(4'b0010, p), 1, 0));
        clear_all();
    endtask

    task automatic t_lock();
        logic [63:0] d, p1, p2;
        p1 = 64'h1234_5678_9ABC_DEF0; p2 = 64'hFEDC_BA98_7654_3210;
        strobe(4'b0011, 1'b0, p1);
        strobe(4'b0100, 1'b0, p2);
        reg_read(16'h0400, d); check("R5 lock word0", d, exp_w0(exp_log(4'b0011, p1), 1, 1));
        reg_read(16'h0408, d); check("R5 lock word1", d, {20'd0, p1[63:20]});
    endtask

    task automatic t_clear();
        logic [63:0] d;
        reg_write(16'h0480, ~(M_FIRST | M_MULT));
        reg_read(16'h0400, d); check("R6 ignored bits", d & (M_FIRST | M_MULT), M_FIRST | M_MULT);
        reg_read(16'h0480, d); check("R6 clear reads zero", d, 64'd0);
        reg_write(16'h0480, M_MULT);
        reg_read(16'h0400, d); check("R6 mult clear", d & (M_FIRST | M_MULT), M_FIRST);
        reg_write(16'h0480, M_FIRST);
        reg_read(16'h0400, d); check("R6 first clear", d & (M_FIRST | M_MULT), 64'd0);
    endtask

    task automatic t_race();
        logic [63:0] d, p1, p2;
        p1 = 64'h0F0F_0F0F_0F0F_0F0F; p2 = 64'hC0DE_FACE_BEEF_0042;
        strobe(4'b0101, 1'b0, p1);
        pulse(1'b1, 4'b0110, 1'b0, p2, 1'b1, 16'h0480, M_FIRST);
        reg_read(16'h0400, d); check("R7 recapture", d, exp_w0(exp_log(4'b0110, p2), 1, 0));
        reg_read(16'h0408, d); check("R7 new address", d, {20'd0, p2[63:20]});
        pulse(1'b1, 4'b0001, 1'b0, p1, 1'b1, 16'h0480, M_MULT);
        reg_read(16'h0400, d); check("R8 mult wins", d, exp_w0(exp_log(4'b0110, p2), 1, 1));
        clear_all();
    endtask

    task automatic t_notify();
        logic [63:0] d;
        strobe(4'b0001, 1'b0, 64'h11);
        check("R10 req pulse", {62'd0, notify_req, notify_rsp}, 64'h2);
        @(negedge clk);
        check("R10 req one cycle", {62'd0, notify_req, notify_rsp}, 64'h0);
        strobe(4'b0100, 1'b1, 64'h22);
        check("R10 rsp disabled", {62'd0, notify_req, notify_rsp}, 64'h0);
        reg_write(16'h0500, 64'hFFFF_FFFF_FFFF_FFF8 | 64'h8);
        reg_read(16'h0500, d); check("R9 ctrl write", d, 64'h8);
        strobe(4'b0100, 1'b1, 64'h33);
        check("R10 rsp pulse while locked", {62'd0, notify_req, notify_rsp}, 64'h1);
        strobe(4'b0001, 1'b0, 64'h44);
        check("R10 req disabled", {62'd0, notify_req, notify_rsp}, 64'h0);
        reg_write(16'h0500, 64'h4);
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [63:0] d, p;
        p = 64'h7777_AAAA_5555_3333;
        strobe(4'b0010, 1'b0, p);
        reg_write(16'h0600, {64{1'b1}});
        reg_write(16'h0404, {64{1'b1}});
        reg_read(16'h0600, d); check("R11 unmapped read", d, 64'd0);
        reg_read(16'h0400, d); check("R11 write no effect", d, exp_w0(exp_log(4'b0010, p), 1, 0));
        reg_read(16'h0500, d); check("R11 ctrl untouched", d, 64'h4);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_capture();
        t_lock();
        t_clear();
        t_race();
        t_notify();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule